// File: doc/BRIEF.md
# Free-Running Compare-Match Timer

This block is a general-purpose timer for a system bus. A 32-bit up-counter advances on a tick taken from one of three tick-enable inputs. A 12-bit main prescaler divides that tick. The slowest source also passes through its own small divider first. A compare register is checked against the counter. When the counter arrives at the compare value, a sticky status flag is set, and the interrupt line rises if it is enabled.

Software reaches the timer through a plain 32-bit register bus. The bus has an address, a write strobe and write data, and read data is returned in the same cycle. A scheduler arms the next event by reading the counter, adding a delay and writing the sum to the compare register. The counter wraps modulo 2^32, so any compare value is legal. A value just behind the count simply lands almost a full wrap later.

Two counting modes exist. In free-run mode the counter passes straight through a match. In restart mode it returns to zero on the count step after it has reached the compare value. Writing zero to the control register stops the timer.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads zero and irq is low. Byte offsets: control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compare 0x10, counter 0x24. Reads of any other offset return zero, and writes to the counter offset are ignored.
- R2: Control bit 0 enables the timer. While it is clear, the counter holds its value and the flag is never set.
- R3: Control bits 8:6 select the tick. Code 1 selects tick_bus, code 2 selects tick_per and code 5 selects the divided tick_osc. Any other code produces no count.
- R4: Prescaler bits 11:0 hold N. The counter advances once every N+1 selected ticks, and N = 0 counts every tick.
- R5: Prescaler bits 15:12 hold M, and tick_osc is divided by M+1 before the main prescaler. Control bit 10 must be set for tick_osc to pass; with it clear, source 5 never counts.
- R6: When control bit 9 is set (free-run), the counter continues upward through a compare match.
- R7: When control bit 9 is clear (restart), the counter goes to zero on the count step that follows the step on which it reached the compare value.
- R8: Status bit 0 is set on the count step that makes the counter equal to the compare value. Writing a compare value equal to the current count does not set it.
- R9: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R10: irq equals status bit 0 AND interrupt-enable bit 0.
- R11: The counter wraps modulo 2^32. A compare value one behind the count produces no match until the counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| tick_bus | input | 1 | Bus clock tick enable (source 1) |
| tick_per | input | 1 | Peripheral clock tick enable (source 2) |
| tick_osc | input | 1 | Oscillator tick enable (source 5) |
| irq | output | 1 | Compare interrupt request, level |

## Verification
The checker assumes that each tick input is a single-cycle enable sampled on the clock. It also assumes that software changes the compare value only while no match is in flight, because a flag rise is related to the compare value held one cycle earlier. The bench drives every tick as a one-cycle pulse and performs each write on its own cycle. It runs counts only from small values, and it exercises the wrap rule with a compare placed one behind the count.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
   localparam int BUS_W  = 32;
   localparam int ADDR_W = 8;

   localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
   localparam logic [ADDR_W-1:0] OFF_PSC  = 8'h04;
   localparam logic [ADDR_W-1:0] OFF_STAT = 8'h08;
   localparam logic [ADDR_W-1:0] OFF_IEN  = 8'h0C;
   localparam logic [ADDR_W-1:0] OFF_CMP  = 8'h10;
   localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h24;

   // control field positions
   localparam int CTL_EN_B   = 0;
   localparam int CTL_SRC_LO = 6;
   localparam int CTL_FREE_B = 9;
   localparam int CTL_OSC_B  = 10;
   localparam int OSC_LO     = 12;

   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_BUS  = 3'd1,
      SRC_PER  = 3'd2,
      SRC_OSC  = 3'd5
   } tick_src_e;

   typedef struct packed {
      logic      run;
      logic      free;
      logic      osc_on;
      logic [2:0] src;
   } ctrl_t;
endpackage

// File: rtl/cmp_timer_tick.sv
module cmp_timer_tick
   import cmp_timer_pkg::*;
#(
   parameter int PSC_W  = 12,
   parameter int OSC_W  = 4,
   parameter bit OSC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ctrl_t            ctrl,
   input  logic [PSC_W-1:0] psc_main,
   input  logic [OSC_W-1:0] psc_osc,
   input  logic             tick_bus,
   input  logic             tick_per,
   input  logic             tick_osc,
   output logic             step
);
   logic osc_pulse;
   logic sel_tick;
   logic [PSC_W-1:0] pcnt_q;

   generate
      if (OSC_EN) begin : g_osc
         logic [OSC_W-1:0] ocnt_q;
         logic osc_live;
         assign osc_live  = ctrl.run && ctrl.osc_on;
         assign osc_pulse = osc_live && tick_osc && (ocnt_q >= psc_osc);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ocnt_q <= '0;
            else if (!osc_live)
               ocnt_q <= '0;
            else if (tick_osc) begin
               if (ocnt_q >= psc_osc) ocnt_q <= '0;
               else                   ocnt_q <= ocnt_q + 1'b1;
            end
         end
      end else begin : g_no_osc
         logic unused_osc;
         assign unused_osc = ^{psc_osc, tick_osc, ctrl.osc_on};
         assign osc_pulse  = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (ctrl.src)
         SRC_BUS: sel_tick = tick_bus;
         SRC_PER: sel_tick = tick_per;
         SRC_OSC: sel_tick = osc_pulse;
         default: sel_tick = 1'b0;
      endcase
   end

   assign step = ctrl.run && sel_tick && (pcnt_q >= psc_main);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt_q <= '0;
      else if (!ctrl.run)
         pcnt_q <= '0;
      else if (sel_tick) begin
         if (pcnt_q >= psc_main) pcnt_q <= '0;
         else                    pcnt_q <= pcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             free,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   assign cnt_nxt = (!free && (cnt_q == cmp)) ? '0 : cnt_q + 1'b1;
   assign hit     = step && (cnt_nxt == cmp);
   assign cnt     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (step) cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
   import cmp_timer_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int PSC_W = 12,
   parameter int OSC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   input  logic              hit,
   input  logic [CNT_W-1:0]  cnt,
   output ctrl_t             ctrl,
   output logic [PSC_W-1:0]  psc_main,
   output logic [OSC_W-1:0]  psc_osc,
   output logic [CNT_W-1:0]  cmp,
   output logic              flag,
   output logic              ien
);
   logic wr_ctrl, wr_psc, wr_stat, wr_ien, wr_cmp;
   logic unused_wdata;

   assign wr_ctrl = wr && (addr == OFF_CTRL);
   assign wr_psc  = wr && (addr == OFF_PSC);
   assign wr_stat = wr && (addr == OFF_STAT);
   assign wr_ien  = wr && (addr == OFF_IEN);
   assign wr_cmp  = wr && (addr == OFF_CMP);
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         psc_main <= '0;
         psc_osc  <= '0;
         cmp      <= '0;
         ien      <= 1'b0;
         flag     <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl.run    <= wdata[CTL_EN_B];
            ctrl.src    <= wdata[CTL_SRC_LO +: 3];
            ctrl.free   <= wdata[CTL_FREE_B];
            ctrl.osc_on <= wdata[CTL_OSC_B];
         end
         if (wr_psc) begin
            psc_main <= wdata[PSC_W-1:0];
            psc_osc  <= wdata[OSC_LO +: OSC_W];
         end
         if (wr_cmp) cmp <= wdata[CNT_W-1:0];
         if (wr_ien) ien <= wdata[0];
         // hardware set takes priority over the software clear
         if (hit)                      flag <= 1'b1;
         else if (wr_stat && wdata[0]) flag <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         OFF_CTRL: begin
            rdata[CTL_EN_B]         = ctrl.run;
            rdata[CTL_SRC_LO +: 3]  = ctrl.src;
            rdata[CTL_FREE_B]       = ctrl.free;
            rdata[CTL_OSC_B]        = ctrl.osc_on;
         end
         OFF_PSC: begin
            rdata[PSC_W-1:0]        = psc_main;
            rdata[OSC_LO +: OSC_W]  = psc_osc;
         end
         OFF_STAT: rdata[0]         = flag;
         OFF_IEN:  rdata[0]         = ien;
         OFF_CMP:  rdata[CNT_W-1:0] = cmp;
         OFF_CNT:  rdata[CNT_W-1:0] = cnt;
         default:  rdata            = '0;
      endcase
   end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
   import cmp_timer_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int PSC_W  = 12,
   parameter int OSC_W  = 4,
   parameter bit OSC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              tick_bus,
   input  logic              tick_per,
   input  logic              tick_osc,
   output logic              irq
);
   localparam int PSC_TOP = OSC_LO + OSC_W;

   initial begin
      if (CNT_W > BUS_W || CNT_W < 2)
         $fatal(1, "cmp_timer: CNT_W out of range");
      if (PSC_W > OSC_LO)
         $fatal(1, "cmp_timer: PSC_W overlaps oscillator field");
      if (PSC_TOP > BUS_W)
         $fatal(1, "cmp_timer: oscillator field exceeds bus");
   end

   ctrl_t            ctrl;
   logic [PSC_W-1:0] psc_main;
   logic [OSC_W-1:0] psc_osc;
   logic [CNT_W-1:0] cmp_val;
   logic [CNT_W-1:0] cnt_val;
   logic             step;
   logic             hit;
   logic             flag;
   logic             ien;

   cmp_timer_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .OSC_W(OSC_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
      .wdata(bus_wdata), .rdata(bus_rdata), .hit(hit), .cnt(cnt_val),
      .ctrl(ctrl), .psc_main(psc_main), .psc_osc(psc_osc), .cmp(cmp_val),
      .flag(flag), .ien(ien)
   );

   cmp_timer_tick #(.PSC_W(PSC_W), .OSC_W(OSC_W), .OSC_EN(OSC_EN)) u_tick (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .psc_main(psc_main),
      .psc_osc(psc_osc), .tick_bus(tick_bus), .tick_per(tick_per),
      .tick_osc(tick_osc), .step(step)
   );

   cmp_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .step(step), .free(ctrl.free),
      .cmp(cmp_val), .cnt(cnt_val), .hit(hit)
   );

   assign irq = flag && ien;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
   import cmp_timer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic              irq,
   input logic              run,
   input logic              flag,
   input logic              ien,
   input logic [CNT_W-1:0]  cnt_val,
   input logic [CNT_W-1:0]  cmp_val
);
   // R2
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt_val));

   // R11
   step_or_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_val != $past(cnt_val)) |->
         (cnt_val == $past(cnt_val) + 1'b1) || (cnt_val == '0));

   // R8
   flag_on_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (cnt_val == $past(cmp_val)));

   // R9
   flag_clear_by_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(bus_wr && bus_addr == OFF_STAT && bus_wdata[0]));

   // R10
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ien |-> !irq);

   // R10
   irq_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && ien) |-> irq);
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .irq(irq), .run(ctrl.run), .flag(flag),
   .ien(ien), .cnt_val(cnt_val), .cmp_val(cmp_val)
);

// File: tb/cmp_timer_tb.sv
`timescale 1ns/1ps
module cmp_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_bus = 1'b0, tick_per = 1'b0, tick_osc = 1'b0;
   logic        irq;
   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cmp_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_bus(tick_bus),
      .tick_per(tick_per), .tick_osc(tick_osc), .irq(irq)
   );

   localparam logic [7:0] A_CTRL = 8'h00, A_PSC = 8'h04, A_STAT = 8'h08,
                          A_IEN = 8'h0C, A_CMP = 8'h10, A_CNT = 8'h24;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // sel: 0 bus, 1 per, 2 osc, 3 all
   task automatic pulse(input int sel, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_bus = (sel == 0 || sel == 3);
         tick_per = (sel == 1 || sel == 3);
         tick_osc = (sel == 2 || sel == 3);
         @(negedge clk);
         tick_bus = 1'b0; tick_per = 1'b0; tick_osc = 1'b0;
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_CTRL, v); chk("R1 ctrl reset", v, 0);
      rd(A_PSC, v);  chk("R1 psc reset", v, 0);
      rd(A_STAT, v); chk("R1 stat reset", v, 0);
      rd(A_CMP, v);  chk("R1 cmp reset", v, 0);
      rd(A_CNT, v);  chk("R1 cnt reset", v, 0);
      chk("R1 irq reset", {31'd0, irq}, 0);
      wr(A_CNT, 32'h55);
      rd(A_CNT, v);  chk("R1 cnt write ignored", v, 0);
      wr(A_CMP, 32'h1234);
      rd(8'h18, v);  chk("R1 unmapped zero", v, 0);
      rd(A_CMP, v);  chk("R1 cmp readback", v, 32'h1234);
   endtask

   task automatic t_count_enable();
      logic [31:0] v;
      wr(A_CTRL, 32'h241);
      pulse(0, 5);
      rd(A_CNT, v); chk("R3 bus tick counts", v, 5);
      wr(A_CTRL, 32'h240);
      pulse(3, 4);
      rd(A_CNT, v); chk("R2 hold when disabled", v, 5);
   endtask

   task automatic t_sources();
      logic [31:0] v;
      wr(A_CTRL, 32'h241);
      pulse(1, 3);
      rd(A_CNT, v); chk("R3 per ignored on src1", v, 5);
      wr(A_CTRL, 32'h281);
      pulse(1, 3);
      rd(A_CNT, v); chk("R3 per on src2", v, 8);
      wr(A_CTRL, 32'h2C1);
      pulse(3, 3);
      rd(A_CNT, v); chk("R3 src3 no count", v, 8);
   endtask

   task automatic t_prescale();
      logic [31:0] v;
      wr(A_PSC, 32'd2);
      wr(A_CTRL, 32'h241);
      pulse(0, 7);
      rd(A_CNT, v); chk("R4 divide by 3", v, 10);
      wr(A_PSC, 32'd0);
      wr(A_CTRL, 32'h240);
   endtask

   task automatic t_osc();
      logic [31:0] v;
      wr(A_PSC, 32'h7000);
      wr(A_CTRL, 32'h741);
      pulse(2, 16);
      rd(A_CNT, v); chk("R5 osc div 8", v, 12);
      wr(A_CTRL, 32'h341);
      pulse(2, 16);
      rd(A_CNT, v); chk("R5 osc gate off", v, 12);
      wr(A_PSC, 32'd0);
   endtask

   task automatic t_free_run();
      logic [31:0] v, c;
      wr(A_CTRL, 32'h241);
      rd(A_CNT, c);
      wr(A_CMP, c);
      rd(A_STAT, v); chk("R8 cmp write no flag", v, 0);
      wr(A_CMP, c + 3);
      pulse(0, 2);
      rd(A_STAT, v); chk("R8 no flag early", v, 0);
      pulse(0, 1);
      rd(A_STAT, v); chk("R8 flag on match", v, 1);
      chk("R10 irq masked", {31'd0, irq}, 0);
      pulse(0, 1);
      rd(A_CNT, v); chk("R6 free run passes", v, c + 4);
   endtask

   task automatic t_irq_clear();
      logic [31:0] v;
      wr(A_IEN, 32'd1);
      chk("R10 irq raised", {31'd0, irq}, 1);
      wr(A_STAT, 32'd0);
      rd(A_STAT, v); chk("R9 write 0 keeps", v, 1);
      wr(A_STAT, 32'd1);
      rd(A_STAT, v); chk("R9 w1c clears", v, 0);
      chk("R10 irq drops", {31'd0, irq}, 0);
      wr(A_IEN, 32'd0);
   endtask

   task automatic t_restart();
      logic [31:0] v, c;
      wr(A_CTRL, 32'h041);
      rd(A_CNT, c);
      wr(A_CMP, c + 2);
      pulse(0, 2);
      rd(A_CNT, v);  chk("R7 reach compare", v, c + 2);
      rd(A_STAT, v); chk("R7 flag at compare", v, 1);
      pulse(0, 1);
      rd(A_CNT, v);  chk("R7 restart zero", v, 0);
      pulse(0, 1);
      rd(A_CNT, v);  chk("R7 count after restart", v, 1);
      wr(A_STAT, 32'd1);
   endtask

   task automatic t_set_wins();
      logic [31:0] v, c;
      wr(A_CTRL, 32'h241);
      rd(A_CNT, c);
      wr(A_CMP, c + 1);
      @(negedge clk);
      tick_bus = 1'b1; bus_addr = A_STAT; bus_wr = 1'b1; bus_wdata = 32'd1;
      @(negedge clk);
      tick_bus = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      rd(A_STAT, v); chk("R9 set beats clear", v, 1);
      wr(A_STAT, 32'd1);
   endtask

   task automatic t_behind();
      logic [31:0] v, c;
      rd(A_CNT, c);
      wr(A_CMP, c - 1);
      pulse(0, 20);
      rd(A_STAT, v); chk("R11 behind no match", v, 0);
      rd(A_CNT, v);  chk("R11 keeps counting", v, c + 20);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count_enable();
      t_sources();
      t_prescale();
      t_osc();
      t_free_run();
      t_irq_clear();
      t_restart();
      t_set_wins();
      t_behind();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule